// File: doc/BRIEF.md
# Serial Test Port Controller

This block is the control core of a board-level serial test port. It follows a sixteen-state controller that advances on each rising edge of the test clock according to the mode-select input. It holds a 4-bit instruction register that loads serially from the serial data input. It routes one of three data paths to the serial output: an external boundary chain, a one-stage bypass stage, or a built-in identification register. The serial output changes only on falling edges, and its enable is high only while an instruction or data shift is in progress.

An external boundary-scan register attaches through the six per-state strobe outputs. Those are capture, shift and update for the data side and for the instruction side. The external register also uses the path-select outputs, its own serial output `bsr_so`, and `ext_mode`, which switches the boundary cells from functional pass-through to test drive. Data moves one bit per test-clock cycle with no valid/ready handshake. The controller has no way to stall the serial stream, so neither side can apply back-pressure. Every transfer completes in the cycle in which the clock paces it.

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller moves between its sixteen states on each rising test-clock edge as selected by `mode_sel`. From Run-Test/Idle, `mode_sel` 1,0,0 reaches the data-shift state, and 1,1,0,0 reaches the instruction-shift state.
- R2: Five consecutive rising edges with `mode_sel` high bring the controller to Test-Logic-Reset from any state. By the time the controller leaves that state, the active instruction is IDCODE again.
- R3: After `test_rst_n` is asserted: the controller is in Test-Logic-Reset; `instr_o` is IDCODE (4'b0001), or BYPASS when the identification register is left out; `sel_id` is 1; `ext_mode` is 0; `ser_oe` is 0.
- R4: In Capture-IR the instruction shift register loads 4'b0001. In Shift-IR it shifts right: `ser_in` enters at the MSB, and bit 0 drives the serial output, so the captured pattern appears LSB first.
- R5: The active instruction changes only on leaving Update-IR or while in Test-Logic-Reset. It keeps its old value throughout an instruction shift.
- R6: Instruction codes: EXTEST is 4'b0000, IDCODE is 4'b0001, SAMPLE/PRELOAD is 4'b0010 and BYPASS is 4'b1111. Every other code behaves as BYPASS. Exactly one of `sel_bsr`, `sel_byp` and `sel_id` is high.
- R7: The bypass stage loads 0 in Capture-DR. In Shift-DR it delays `ser_in` by one clock on its way to the serial output.
- R8: With IDCODE active, a data scan shifts out the 32-bit `ID_VALUE` (default 32'h4BA06C35), LSB first.
- R9: With EXTEST or SAMPLE/PRELOAD active, the serial output in Shift-DR follows `bsr_so`. `ext_mode` is high only when EXTEST is active and the controller is not in Test-Logic-Reset.
- R10: `ser_out` and `ser_oe` update on falling test-clock edges. `ser_oe` is high only in the Shift-IR and Shift-DR states.
- R11: Each strobe output (`dr_capture`, `dr_shift`, `dr_update`, `ir_capture`, `ir_shift`, `ir_update`) is high exactly while the controller is in the matching state. At most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low test reset |
| mode_sel | input | 1 | Controller steering bit, sampled on rising edges |
| ser_in | input | 1 | Serial data input |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| ser_out | output | 1 | Serial data output, changes on falling edges |
| ser_oe | output | 1 | Output enable for `ser_out` |
| instr_o | output | 4 | Active instruction |
| sel_bsr | output | 1 | Boundary chain selected |
| sel_byp | output | 1 | Bypass stage selected |
| sel_id | output | 1 | Identification register selected |
| ext_mode | output | 1 | Boundary cells drive test values |
| dr_capture | output | 1 | Controller in Capture-DR |
| dr_shift | output | 1 | Controller in Shift-DR |
| dr_update | output | 1 | Controller in Update-DR |
| ir_capture | output | 1 | Controller in Capture-IR |
| ir_shift | output | 1 | Controller in Shift-IR |
| ir_update | output | 1 | Controller in Update-IR |

## Verification
The assertions assume that `mode_sel`, `ser_in` and `bsr_so` are steady around each rising edge. They also assume that `test_rst_n` is held low before the first edge, so the consecutive-high counter and the controller start aligned. The bench changes every input just after a falling edge and releases reset in the same way. A whole half period therefore separates each input change from the edge that samples it. The bench drives `bsr_so` as a constant for a complete scan, so the expected serial stream does not depend on how the external chain is timed.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_t;

  typedef struct packed {
    logic in_reset;
    logic cap_dr;
    logic shf_dr;
    logic upd_dr;
    logic cap_ir;
    logic shf_ir;
    logic upd_ir;
  } tap_strobe_t;

  function automatic tap_st_t tap_next(input tap_st_t s, input logic t);
    case (s)
      ST_RESET:  tap_next = t ? ST_RESET  : ST_IDLE;
      ST_IDLE:   tap_next = t ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: tap_next = t ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: tap_next = t ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: tap_next = t ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: tap_next = t ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: tap_next = t ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: tap_next = t ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: tap_next = t ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: tap_next = t ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: tap_next = t ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: tap_next = t ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: tap_next = t ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: tap_next = t ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: tap_next = t ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: tap_next = t ? ST_SEL_DR : ST_IDLE;
      default:   tap_next = ST_RESET;
    endcase
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_sel,
  output tap_strobe_t strb
);

  tap_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= tap_next(st, mode_sel);
  end

  always_comb begin
    strb          = '0;
    strb.in_reset = (st == ST_RESET);
    strb.cap_dr   = (st == ST_CAP_DR);
    strb.shf_dr   = (st == ST_SHF_DR);
    strb.upd_dr   = (st == ST_UPD_DR);
    strb.cap_ir   = (st == ST_CAP_IR);
    strb.shf_ir   = (st == ST_SHF_IR);
    strb.upd_ir   = (st == ST_UPD_IR);
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_port_pkg::*;
#(
  parameter bit HAS_ID = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_in,
  input  logic            in_reset,
  input  logic            cap_ir,
  input  logic            shf_ir,
  input  logic            upd_ir,
  output logic            ir_so,
  output logic [IR_W-1:0] instr,
  output logic            sel_bsr,
  output logic            sel_byp,
  output logic            sel_id,
  output logic            ext_mode
);

  localparam logic [IR_W-1:0] DEF_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

  logic [IR_W-1:0] ir_sr;
  logic            id_hit;

  // serial instruction shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ir_sr <= IR_CAPTURE_PAT;
    else if (cap_ir) ir_sr <= IR_CAPTURE_PAT;
    else if (shf_ir) ir_sr <= {ser_in, ir_sr[IR_W-1:1]};
  end

  // parallel active instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        instr <= DEF_OP;
    else if (in_reset) instr <= DEF_OP;
    else if (upd_ir)   instr <= ir_sr;
  end

  generate
    if (HAS_ID) begin : g_id_dec
      assign id_hit = (instr == OP_IDCODE);
    end else begin : g_no_id_dec
      assign id_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_bsr = 1'b0;
    sel_byp = 1'b0;
    sel_id  = 1'b0;
    if (instr == OP_EXTEST || instr == OP_SAMPLE) sel_bsr = 1'b1;
    else if (id_hit)                              sel_id  = 1'b1;
    else                                          sel_byp = 1'b1;
  end

  assign ext_mode = (instr == OP_EXTEST) && !in_reset;
  assign ir_so    = ir_sr[0];

endmodule

// File: rtl/scan_dr_path.sv
module scan_dr_path #(
  parameter bit              HAS_ID   = 1'b1,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA0_6C35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic cap_dr,
  input  logic shf_dr,
  input  logic shf_ir,
  input  logic sel_bsr,
  input  logic sel_id,
  input  logic ir_so,
  input  logic bsr_so,
  output logic ser_out,
  output logic ser_oe
);

  logic byp_q;
  logic id_so;
  logic mux_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (cap_dr) byp_q <= 1'b0;
    else if (shf_dr) byp_q <= ser_in;
  end

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                id_sr <= ID_VALUE;
        else if (cap_dr && sel_id) id_sr <= ID_VALUE;
        else if (shf_dr && sel_id) id_sr <= {ser_in, id_sr[ID_W-1:1]};
      end
      assign id_so = id_sr[0];
    end else begin : g_no_id
      assign id_so = 1'b0;
    end
  endgenerate

  always_comb begin
    if (shf_ir)       mux_bit = ir_so;
    else if (sel_bsr) mux_bit = bsr_so;
    else if (sel_id)  mux_bit = id_so;
    else              mux_bit = byp_q;
  end

  // output retimed to the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else begin
      ser_out <= mux_bit;
      ser_oe  <= shf_ir | shf_dr;
    end
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter bit              HAS_ID   = 1'b1,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA0_6C35
) (
  input  logic            test_clk,
  input  logic            test_rst_n,
  input  logic            mode_sel,
  input  logic            ser_in,
  input  logic            bsr_so,
  output logic            ser_out,
  output logic            ser_oe,
  output logic [IR_W-1:0] instr_o,
  output logic            sel_bsr,
  output logic            sel_byp,
  output logic            sel_id,
  output logic            ext_mode,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update,
  output logic            ir_capture,
  output logic            ir_shift,
  output logic            ir_update
);

  tap_strobe_t strb;
  logic        at_reset;
  logic        ir_so;

  scan_fsm u_fsm (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .mode_sel (mode_sel),
    .strb     (strb)
  );

  assign at_reset   = strb.in_reset;
  assign dr_capture = strb.cap_dr;
  assign dr_shift   = strb.shf_dr;
  assign dr_update  = strb.upd_dr;
  assign ir_capture = strb.cap_ir;
  assign ir_shift   = strb.shf_ir;
  assign ir_update  = strb.upd_ir;

  scan_ir #(.HAS_ID(HAS_ID)) u_ir (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .ser_in   (ser_in),
    .in_reset (at_reset),
    .cap_ir   (strb.cap_ir),
    .shf_ir   (strb.shf_ir),
    .upd_ir   (strb.upd_ir),
    .ir_so    (ir_so),
    .instr    (instr_o),
    .sel_bsr  (sel_bsr),
    .sel_byp  (sel_byp),
    .sel_id   (sel_id),
    .ext_mode (ext_mode)
  );

  scan_dr_path #(.HAS_ID(HAS_ID), .ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .clk     (test_clk),
    .rst_n   (test_rst_n),
    .ser_in  (ser_in),
    .cap_dr  (strb.cap_dr),
    .shf_dr  (strb.shf_dr),
    .shf_ir  (strb.shf_ir),
    .sel_bsr (sel_bsr),
    .sel_id  (sel_id),
    .ir_so   (ir_so),
    .bsr_so  (bsr_so),
    .ser_out (ser_out),
    .ser_oe  (ser_oe)
  );

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sel,
  input logic       in_tlr,
  input logic       ser_oe,
  input logic       ext_mode,
  input logic [3:0] instr,
  input logic       sel_bsr,
  input logic       sel_byp,
  input logic       sel_id,
  input logic       dr_capture,
  input logic       dr_shift,
  input logic       dr_update,
  input logic       ir_capture,
  input logic       ir_shift,
  input logic       ir_update
);

  logic [2:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= 3'd0;
    else if (!mode_sel)      hi_cnt <= 3'd0;
    else if (hi_cnt < 3'd5)  hi_cnt <= hi_cnt + 3'd1;
  end

  p_five_high_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == 3'd5) |-> in_tlr);

  p_instr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ir_update) && !$past(in_tlr)) |-> $stable(instr));

  p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_bsr, sel_byp, sel_id}));

  p_ext_low_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_tlr |-> !ext_mode);

  p_oe_tracks_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe == (ir_shift || dr_shift));

  p_strobe_onehot0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update, in_tlr}));

endmodule

bind scan_port_ctrl scan_port_chk u_chk (
  .clk        (test_clk),
  .rst_n      (test_rst_n),
  .mode_sel   (mode_sel),
  .in_tlr     (at_reset),
  .ser_oe     (ser_oe),
  .ext_mode   (ext_mode),
  .instr      (instr_o),
  .sel_bsr    (sel_bsr),
  .sel_byp    (sel_byp),
  .sel_id     (sel_id),
  .dr_capture (dr_capture),
  .dr_shift   (dr_shift),
  .dr_update  (dr_update),
  .ir_capture (ir_capture),
  .ir_shift   (ir_shift),
  .ir_update  (ir_update)
);

// File: tb/test_scan_port_ctrl.sv
module test_scan_port_ctrl;

  localparam logic [31:0] ID_VAL = 32'h4BA0_6C35;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b1;
  logic       ser_in = 1'b0;
  logic       bsr_so = 1'b0;
  logic       ser_out, ser_oe, sel_bsr, sel_byp, sel_id, ext_mode;
  logic       dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update;
  logic [3:0] instr_o;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    string req;
    logic  b;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  scan_port_ctrl i_scan_port_ctrl (
    .test_clk(clk), .test_rst_n(rst_n), .mode_sel(mode_sel), .ser_in(ser_in),
    .bsr_so(bsr_so), .ser_out(ser_out), .ser_oe(ser_oe), .instr_o(instr_o),
    .sel_bsr(sel_bsr), .sel_byp(sel_byp), .sel_id(sel_id), .ext_mode(ext_mode),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: pops one expected bit per shift cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (ser_oe === 1'b1 && exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        chk(it.req, {63'd0, ser_out}, {63'd0, it.b});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic tick(input logic t, input logic d);
    mode_sel = t;
    ser_in   = d;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] dexp,
                         input string req);
    for (int i = 0; i < n; i++) begin
      exp_t it;
      it.req = req;
      it.b   = dexp[i];
      exp_q.push_back(it);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R1/R11 dr_capture", {63'd0, dr_capture}, 64'd1);
    tick(1'b0, 1'b0);
    chk("R1/R11 dr_shift", {63'd0, dr_shift}, 64'd1);
    chk("R10 oe in shift", {63'd0, ser_oe}, 64'd1);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    chk("R10 oe after shift", {63'd0, ser_oe}, 64'd0);
    tick(1'b1, 1'b0);
    chk("R11 dr_update", {63'd0, dr_update}, 64'd1);
    tick(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [3:0] code, input string req);
    logic [3:0] old;
    for (int i = 0; i < 4; i++) begin
      exp_t it;
      it.req = req;
      it.b   = (i == 0);
      exp_q.push_back(it);
    end
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R1/R11 ir_capture", {63'd0, ir_capture}, 64'd1);
    tick(1'b0, 1'b0);
    chk("R1/R11 ir_shift", {63'd0, ir_shift}, 64'd1);
    old = instr_o;
    for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
    chk("R5 instr held", {60'd0, instr_o}, {60'd0, old});
    tick(1'b1, 1'b0);
    chk("R11 ir_update", {63'd0, ir_update}, 64'd1);
    tick(1'b0, 1'b0);
    chk("R5 instr loaded", {60'd0, instr_o}, {60'd0, code});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    chk("R3 instr", {60'd0, instr_o}, 64'h1);
    chk("R3 sel_id", {63'd0, sel_id}, 64'd1);
    chk("R3 ext_mode", {63'd0, ext_mode}, 64'd0);
    chk("R3 ser_oe", {63'd0, ser_oe}, 64'd0);
    tick(1'b0, 1'b0);

    scan_dr(32, 64'd0, {32'd0, ID_VAL}, "R8 id bit");

    scan_ir(4'b0000, "R4 ir capture bit");
    chk("R6 extest sel_bsr", {63'd0, sel_bsr}, 64'd1);
    chk("R9 extest ext_mode", {63'd0, ext_mode}, 64'd1);
    bsr_so = 1'b1;
    scan_dr(6, 64'd0, {64{1'b1}}, "R9 bsr high");
    bsr_so = 1'b0;
    scan_dr(6, {64{1'b1}}, 64'd0, "R9 bsr low");

    scan_ir(4'b0010, "R4 ir capture bit");
    chk("R6 sample sel_bsr", {63'd0, sel_bsr}, 64'd1);
    chk("R9 sample ext_mode", {63'd0, ext_mode}, 64'd0);

    scan_ir(4'b1111, "R4 ir capture bit");
    chk("R6 bypass sel_byp", {63'd0, sel_byp}, 64'd1);
    scan_dr(5, 64'b01101, {64'b01101, 1'b0} >> 0, "R7 bypass bit");

    scan_ir(4'b0101, "R4 ir capture bit");
    chk("R6 undefined sel_byp", {63'd0, sel_byp}, 64'd1);
    chk("R6 undefined sel_bsr", {63'd0, sel_bsr}, 64'd0);
    chk("R6 undefined sel_id", {63'd0, sel_id}, 64'd0);
    scan_dr(4, 64'b1011, {64'b1011, 1'b0} >> 0, "R7 undefined bypass bit");

    scan_ir(4'b0000, "R4 ir capture bit");
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R1 reached dr shift", {63'd0, dr_shift}, 64'd1);
    repeat (5) tick(1'b1, 1'b0);
    chk("R2 ext_mode low", {63'd0, ext_mode}, 64'd0);
    chk("R2 no shift", {63'd0, dr_shift}, 64'd0);
    chk("R10 oe low in reset", {63'd0, ser_oe}, 64'd0);
    tick(1'b0, 1'b0);
    chk("R2 instr idcode", {60'd0, instr_o}, 64'h1);
    chk("R2 sel_id", {63'd0, sel_id}, 64'd1);
    scan_dr(32, 64'd0, {32'd0, ID_VAL}, "R2 id after reset");

    tick(1'b0, 1'b0);
    chk("R8 all bits consumed", exp_q.size(), 64'd0);
    finish_run();
  end

endmodule